// File: doc/BRIEF.md
# I2C Target Interface with General Call

This block is the receiving end of a two-wire serial bus. It watches already-synchronized clock and data lines and answers when the first byte after a START carries its fixed 7-bit address or the general-call address. It drives the bus only through two open-drain pull-down enables, one for the data line and one for the clock line.

On a write, the block takes each incoming byte, hands it to the user side as a one-cycle strobe, and acknowledges it. The user side can refuse a byte by asserting a full flag. On a read, the block takes bytes from the user side and shifts them out until the bus controller declines one. When the parameter `STRETCH` is set, the block holds the clock line low at each byte boundary while the user side is not ready. A START or STOP at any point abandons the current byte.

Top module: `i2c_target`

## Requirements
- R1: The first byte after a START is shifted in MSB first: seven address bits, then a direction bit (0 = write, 1 = read). When the address equals `OWN_ADDR`, the block pulls SDA low for the whole ninth clock.
- R2: When the address is neither `OWN_ADDR` nor the general call, the block never pulls SDA low and delivers no bytes until the next START.
- R3: During a write, each 8-bit data byte (MSB first) appears on `rx_data` with `rx_valid` high for exactly one cycle after its eighth clock falls. The block acknowledges the byte on the ninth clock.
- R4: If `rx_full` is high when the eighth clock of a write byte falls, the byte is not acknowledged and `rx_valid` does not pulse. The block then ignores the bus until the next START.
- R5: Address 0000000 with the direction bit 0 is acknowledged like the block's own address. Bytes received under it carry `rx_gc` = 1; bytes received under `OWN_ADDR` carry `rx_gc` = 0.
- R6: Address 0000000 with the direction bit 1 is not acknowledged. The block drives nothing and takes no transmit byte.
- R7: After a read address is acknowledged, the block samples `tx_data` in the cycle where `tx_load` is high and drives it MSB first, one bit per clock. The block releases SDA for the ninth clock.
- R8: When the bus controller acknowledges a read byte (SDA low on the ninth clock), the next byte follows. When it does not, the block releases SDA, loads no further byte, and stays silent until the next START.
- R9: With `STRETCH` = 1 and `usr_ready` low when the ninth clock falls, the block holds SCL low and takes no transmit byte. Within two cycles of `usr_ready` going high it releases SCL and resumes.
- R10: After reset, or after a START or STOP at any bit position, both line enables are released. A START returns the block to address matching. After a STOP, bytes clocked without a new START are ignored.
- R11: `sda_oe` changes only while SCL is low, one system clock after the SCL falling edge is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_gc | output | 1 | Received byte belongs to a general call |
| rx_full | input | 1 | User side cannot accept a byte; NACK it |
| tx_load | output | 1 | tx_data is sampled in this cycle |
| tx_data | input | 8 | Next byte to transmit on a read |
| usr_ready | input | 1 | User side ready; low requests clock stretching |

## Verification
A bit counter that is off by one shows up as an acknowledge on the wrong clock. The bus controller then reads a NACK on the ninth clock of the same byte, and a write byte arrives on `rx_data` shifted by one place at its strobe. A stuck stretch state shows as SCL held low at the very next rising edge the controller attempts. A wrong direction or general-call decision shows within the first data byte as data driven where none was due, or as a missing or extra `tx_load`. A missed START or STOP shows on the next address byte as an absent or spurious acknowledge.

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter logic [6:0] OWN_ADDR = 7'h5A,
  parameter bit         STRETCH  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_gc,
  input  logic       rx_full,
  output logic       tx_load,
  input  logic [7:0] tx_data,
  input  logic       usr_ready
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_HOLD
  } st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, mack;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start    = scl_i & scl_q & sda_q & ~sda_i;
  wire stop     = scl_i & scl_q & ~sda_q & sda_i;
  wire gc_hit   = (sh[7:1] == 7'd0) && !sh[0];
  wire addr_hit = (sh[7:1] == OWN_ADDR) || gc_hit;
  wire go       = usr_ready || !STRETCH;
  wire byte_end = scl_fall && (cnt == 4'd8);
  wire advance  = (scl_fall && (st == S_AACK || st == S_RACK || (st == S_TACK && mack)))
                || (st == S_HOLD);

  assign tx_load = rw && go && advance && !start && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_gc    <= 1'b0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      rx_valid <= 1'b0;
      scl_oe   <= 1'b0;
      if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (advance) begin
        cnt <= '0;
        if (!go) begin
          st     <= S_HOLD;
          scl_oe <= 1'b1;
          sda_oe <= 1'b0;
        end else begin
          scl_oe <= (st == S_HOLD);
          if (rw) begin
            sh     <= tx_data;
            sda_oe <= ~tx_data[7];
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  rx_gc  <= gc_hit;
                  st     <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (!rx_full) begin
                sda_oe   <= 1'b1;
                rx_valid <= 1'b1;
                rx_data  <= sh;
                st       <= S_RACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= S_TACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_i;
            else if (scl_fall) st <= S_IDLE;
          end
          S_AACK, S_RACK: ;
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_valid,
  input logic rx_full,
  input logic start_seen,
  input logic stop_seen
);

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  a_r9_stretch_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !scl_i);

  a_r4_no_strobe_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(rx_full));

  a_r3_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sda_oe);

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!sda_oe && !scl_oe));

  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !sda_oe);

endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .rx_valid   (rx_valid),
  .rx_full    (rx_full),
  .start_seen (start),
  .stop_seen  (stop)
);

// File: tb/i2c_target_bench.sv
module i2c_target_bench;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic rx_full = 1'b0, usr_ready = 1'b1;
  logic scl_oe, sda_oe, rx_valid, rx_gc, tx_load;
  logic [7:0] rx_data, tx_data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int tx_cnt = 0, rx_cnt = 0, sda_bad = 0, sda_on = 0;
  logic [7:0] rx_log [0:63];
  logic       gc_log [0:63];
  logic       sda_oe_d = 1'b0;
  bit         done = 1'b0;

  i2c_target #(.OWN_ADDR(ADDR), .STRETCH(1'b1)) u_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_gc(rx_gc), .rx_full(rx_full), .tx_load(tx_load), .tx_data(tx_data),
    .usr_ready(usr_ready));

  function automatic logic [7:0] pat(int k);
    return 8'h96 ^ 8'(k * 37);
  endfunction

  assign tx_data = pat(tx_cnt);

  always @(posedge clk) begin
    if (rst_n && tx_load) tx_cnt <= tx_cnt + 1;
    if (rst_n && rx_valid) begin
      rx_log[rx_cnt] <= rx_data;
      gc_log[rx_cnt] <= rx_gc;
      rx_cnt <= rx_cnt + 1;
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (sda_oe !== sda_oe_d && scl_line) sda_bad++;
    if (sda_oe) sda_on++;
    sda_oe_d = sda_oe;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    nclk(1);
    while (!scl_line) nclk(1);
  endtask

  task automatic m_start();
    sda_m = 1'b1; nclk(Q);
    scl_m = 1'b1; wait_high(); nclk(Q);
    sda_m = 1'b0; nclk(Q);
    scl_m = 1'b0; nclk(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; nclk(Q);
    scl_m = 1'b1; wait_high(); nclk(Q);
    sda_m = 1'b1; nclk(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; nclk(Q);
    scl_m = 1'b1; wait_high(); nclk(Q);
    r = sda_line; nclk(Q);
    scl_m = 1'b0; nclk(Q);
  endtask

  task automatic m_wr(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rd(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(~give_ack, r);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R10", "lines released after reset", {scl_oe, sda_oe}, 0);
    chk(rx_valid == 1'b0 && tx_load == 1'b0, "R10", "no strobes after reset", {rx_valid, tx_load}, 0);
  endtask

  task automatic t_own_write();
    logic a; int base = rx_cnt;
    m_start();
    m_wr({ADDR, 1'b0}, a);   chk(a, "R1", "own address ack", a, 1);
    m_wr(8'hA5, a);          chk(a, "R3", "byte 0 ack", a, 1);
    m_wr(8'h3C, a);          chk(a, "R3", "byte 1 ack", a, 1);
    m_stop();
    chk(rx_cnt == base + 2, "R3", "strobe count", rx_cnt - base, 2);
    chk(rx_log[base] == 8'hA5, "R3", "byte 0 value", rx_log[base], 8'hA5);
    chk(rx_log[base+1] == 8'h3C, "R3", "byte 1 value", rx_log[base+1], 8'h3C);
    chk(gc_log[base] == 1'b0, "R5", "own address gc flag", gc_log[base], 0);
  endtask

  task automatic t_other_addr();
    logic a; int base = rx_cnt; int on0 = sda_on;
    m_start();
    m_wr({7'h21, 1'b0}, a);  chk(!a, "R2", "foreign address nack", a, 0);
    m_wr(8'h00, a);          chk(!a, "R2", "foreign data nack", a, 0);
    m_stop();
    chk(rx_cnt == base, "R2", "no strobe", rx_cnt - base, 0);
    chk(sda_on == on0, "R2", "SDA never pulled", sda_on - on0, 0);
  endtask

  task automatic t_full();
    logic a; int base = rx_cnt;
    m_start();
    m_wr({ADDR, 1'b0}, a);   chk(a, "R1", "address ack before full", a, 1);
    rx_full = 1'b1;
    m_wr(8'h55, a);          chk(!a, "R4", "full byte nack", a, 0);
    rx_full = 1'b0;
    m_wr(8'h66, a);          chk(!a, "R4", "ignored until START", a, 0);
    m_stop();
    chk(rx_cnt == base, "R4", "no strobe when full", rx_cnt - base, 0);
  endtask

  task automatic t_gcall();
    logic a; int base = rx_cnt;
    m_start();
    m_wr(8'h00, a);          chk(a, "R5", "general call ack", a, 1);
    m_wr(8'h77, a);          chk(a, "R5", "general call data ack", a, 1);
    m_stop();
    chk(rx_cnt == base + 1 && rx_log[base] == 8'h77, "R5", "general call byte", rx_log[base], 8'h77);
    chk(gc_log[base] == 1'b1, "R5", "general call flag", gc_log[base], 1);
  endtask

  task automatic t_gc_read();
    logic a; logic [7:0] d; int k = tx_cnt;
    m_start();
    m_wr(8'h01, a);          chk(!a, "R6", "general call read nack", a, 0);
    m_rd(1'b0, d);           chk(d == 8'hFF, "R6", "nothing driven", d, 8'hFF);
    m_stop();
    chk(tx_cnt == k, "R6", "no transmit load", tx_cnt - k, 0);
  endtask

  task automatic t_read();
    logic a; logic [7:0] d; int k = tx_cnt;
    m_start();
    m_wr({ADDR, 1'b1}, a);   chk(a, "R7", "read address ack", a, 1);
    m_rd(1'b1, d);           chk(d == pat(k), "R7", "read byte 0", d, pat(k));
    m_rd(1'b0, d);           chk(d == pat(k+1), "R8", "read byte after ack", d, pat(k+1));
    chk(tx_cnt == k + 2, "R7", "loads for two bytes", tx_cnt - k, 2);
    m_rd(1'b0, d);           chk(d == 8'hFF, "R8", "released after nack", d, 8'hFF);
    chk(tx_cnt == k + 2, "R8", "no load after nack", tx_cnt - k, 2);
    m_stop();
  endtask

  task automatic t_stretch();
    logic a; logic [7:0] d; int base = rx_cnt; int k;
    usr_ready = 1'b0;
    m_start();
    m_wr({ADDR, 1'b0}, a);   chk(a, "R9", "address ack before stretch", a, 1);
    fork
      m_wr(8'h81, a);
      begin
        nclk(40);
        chk(scl_oe && !scl_line, "R9", "SCL held while not ready", scl_oe, 1);
        usr_ready = 1'b1;
        nclk(2);
        chk(!scl_oe, "R9", "SCL released after ready", scl_oe, 0);
      end
    join
    chk(a && rx_log[base] == 8'h81, "R9", "byte after stretch", rx_log[base], 8'h81);
    m_stop();
    usr_ready = 1'b0;
    k = tx_cnt;
    m_start();
    m_wr({ADDR, 1'b1}, a);
    fork
      m_rd(1'b0, d);
      begin
        nclk(40);
        chk(tx_cnt == k, "R9", "no load while held", tx_cnt - k, 0);
        chk(scl_oe, "R9", "read stretch holds SCL", scl_oe, 1);
        usr_ready = 1'b1;
      end
    join
    chk(d == pat(k), "R9", "read byte after stretch", d, pat(k));
    m_stop();
  endtask

  task automatic t_abort();
    logic a, r; int base = rx_cnt;
    m_start();
    m_wr({ADDR, 1'b0}, a);
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
    m_start();
    m_wr({ADDR, 1'b0}, a);   chk(a, "R10", "address ack after repeated START", a, 1);
    m_wr(8'h42, a);
    chk(rx_cnt == base + 1 && rx_log[base] == 8'h42, "R10", "only full byte kept", rx_log[base], 8'h42);
    for (int i = 0; i < 5; i++) m_bit(1'b0, r);
    m_stop();
    chk(!sda_oe && !scl_oe, "R10", "released after STOP", {scl_oe, sda_oe}, 0);
    m_wr({ADDR, 1'b0}, a);   chk(!a, "R10", "ignored without START", a, 0);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    nclk(5);
    t_reset();
    rst_n = 1'b1;
    nclk(5);
    t_reset();
    t_own_write();
    t_other_addr();
    t_full();
    t_gcall();
    t_gc_read();
    t_read();
    t_stretch();
    t_abort();
    chk(sda_bad == 0, "R11", "SDA changed while SCL high", sda_bad, 0);
    finish_run();
  end
endmodule